// File: doc/BRIEF.md
# Synchronous Receive CRC Checker

This block checks the CRC of a byte-synchronous receive stream one bit at a time. Serial bits arrive with a per-cycle valid qualifier. An internal bit counter marks each character boundary, using a programmable character length of 5 to 8 bits. Every received bit passes through an 8-stage delay line before it can reach the 16-bit CRC register. This leaves software one full character time to decide whether a character takes part in the check.

The include decision for a character is made once, on the cycle in which its final bit arrives (the character load). At that point the checker-enable input must be high and the sync-strip flag low for the character's bits to be accumulated as they leave the delay line. As a result, accumulation always starts and stops on a character boundary. Stripped sync characters never touch the CRC.

The polynomial and the preset value are selectable. While the receiver hunts for synchronisation, the register is held at its preset value. An explicit reset command also presets the register. A good-CRC flag reports a zero remainder.

Top module: `sync_rx_crc_chk`

## Requirements
- R1: `poly_sel`=1 selects x^16+x^15+x^2+1 and `poly_sel`=0 selects x^16+x^12+x^5+1. The register advances MSB-first, one bit per accumulated bit: feedback = crc[15] xor bit, then crc = (crc<<1) xor (feedback ? poly : 0).
- R2: The preset value is 16'hFFFF when `preset_ones`=1 and 16'h0000 when it is 0.
- R3: While `hunt` is 1, the register is loaded with the preset on every clock. The delay line and its include tags are cleared, and the bit count restarts. The first bit after `hunt` falls is bit 1 of a new character.
- R4: `crc_reset`=1 loads the preset on the next clock and takes priority over accumulation. `hunt` has priority over `crc_reset`.
- R5: `crc_q` changes only on clocks with `hunt`, `crc_reset` or `rx_bit_vld` high. With all three low it holds its value.
- R6: A received bit enters the CRC only when it leaves the 8-stage delay line, that is, on the valid cycle that brings in the 8th later bit. Before that, the register still holds its earlier value.
- R7: Whether a character is included is decided from `crc_en` on its load cycle only. The level of `crc_en` on the character's other bit cycles has no effect.
- R8: A character whose load cycle has `sync_strip`=1 is excluded from the CRC, even when `crc_en` is 1.
- R9: The character length is 5 + `char_len` bits (00=5, 01=6, 10=7, 11=8). `char_load` is high in the cycle of each character's last valid bit.
- R10: `crc_ok` is 1 exactly when `crc_q` is zero. A frame followed by its uncomplemented CRC, sent high byte first, leaves zero with either preset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit_vld | input | 1 | A received bit is present this cycle |
| rx_bit | input | 1 | Received serial bit |
| char_len | input | 2 | Character length code, bits = 5 + code |
| poly_sel | input | 1 | 1: CRC-16 polynomial, 0: CCITT polynomial |
| preset_ones | input | 1 | Preset value select, 1: all ones, 0: all zeros |
| crc_en | input | 1 | Checker enable, sampled at character load |
| sync_strip | input | 1 | Character at this load is a stripped sync |
| crc_reset | input | 1 | Reset-checker command |
| hunt | input | 1 | Receiver is in hunt mode |
| crc_q | output | 16 | Current CRC remainder |
| crc_ok | output | 1 | Remainder is zero |
| char_load | output | 1 | Character boundary strobe |

## Verification
Some behaviours are checked by the bound assertions on every cycle: presetting under hunt and under the reset command, the register holding when no bit, hunt or reset is present, and the spacing of character loads against the programmed length. Other behaviours only the bench scenarios can show. These are the actual remainder values for each polynomial and preset, the eight-bit lag of the delay line, and the fact that the enable and strip inputs matter only on a load cycle. They also include the zero remainder after an appended CRC and the recovery of character alignment after hunt.

// File: rtl/crc_rx_pkg.sv
package crc_rx_pkg;
    localparam int CRC_W = 16;
    localparam logic [CRC_W-1:0] POLY_A = 16'h8005;  // x^16+x^15+x^2+1
    localparam logic [CRC_W-1:0] POLY_B = 16'h1021;  // x^16+x^12+x^5+1

    function automatic logic [CRC_W-1:0] crc_advance(
        input logic [CRC_W-1:0] cur,
        input logic             din,
        input logic             use_a
    );
        logic fb;
        fb = cur[CRC_W-1] ^ din;
        return {cur[CRC_W-2:0], 1'b0} ^ (fb ? (use_a ? POLY_A : POLY_B) : '0);
    endfunction

    function automatic logic [CRC_W-1:0] preset_of(input logic ones);
        return ones ? '1 : '0;
    endfunction
endpackage

// File: rtl/crc_char_count.sv
module crc_char_count #(
    parameter int LEN_W   = 2,
    parameter int MIN_LEN = 5,
    localparam int MAX_LEN = MIN_LEN + (1 << LEN_W) - 1,
    localparam int CNT_W   = $clog2(MAX_LEN),
    localparam int BITS_W  = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hunt,
    input  logic              bit_vld,
    input  logic [LEN_W-1:0]  len_code,
    output logic              load,
    output logic [BITS_W-1:0] bits_per_char
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [BITS_W-1:0] last_idx;

    always_comb begin
        bits_per_char = BITS_W'(MIN_LEN) + BITS_W'(len_code);
        last_idx      = bits_per_char - 1'b1;
        load          = bit_vld && !hunt && ({1'b0, st_q.cnt} >= last_idx);
        st_d          = st_q;
        if (hunt) begin
            st_d.cnt = '0;
        end else if (bit_vld) begin
            st_d.cnt = load ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/crc_delay_line.sv
module crc_delay_line #(
    parameter int DEPTH  = 8,
    parameter int BITS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hunt,
    input  logic              shift,
    input  logic              din,
    input  logic              load,
    input  logic              incl,
    input  logic [BITS_W-1:0] char_bits,
    output logic              dout,
    output logic              dout_tag
);
    typedef struct packed {
        logic [DEPTH-1:0] data;
        logic [DEPTH-1:0] tag;
    } dly_state_t;

    dly_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hunt) begin
            st_d = '0;
        end else if (shift) begin
            st_d.data = {st_q.data[DEPTH-2:0], din};
            st_d.tag  = {st_q.tag[DEPTH-2:0], 1'b0};
            if (load) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (i < int'(char_bits)) st_d.tag[i] = incl;
                end
            end
        end
        dout     = st_q.data[DEPTH-1];
        dout_tag = st_q.tag[DEPTH-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/crc_lfsr16.sv
module crc_lfsr16
    import crc_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hunt,
    input  logic             clr,
    input  logic             step,
    input  logic             din,
    input  logic             use_a,
    input  logic             preset_ones,
    output logic [CRC_W-1:0] crc
);
    typedef struct packed {
        logic [CRC_W-1:0] rem;
    } lfsr_state_t;

    lfsr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hunt || clr) begin
            st_d.rem = preset_of(preset_ones);
        end else if (step) begin
            st_d.rem = crc_advance(st_q.rem, din, use_a);
        end
        crc = st_q.rem;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sync_rx_crc_chk.sv
module sync_rx_crc_chk
    import crc_rx_pkg::*;
#(
    parameter int LEN_W   = 2,
    parameter int MIN_LEN = 5,
    parameter int DEPTH   = 8,
    localparam int MAX_LEN = MIN_LEN + (1 << LEN_W) - 1,
    localparam int BITS_W  = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_bit_vld,
    input  logic             rx_bit,
    input  logic [LEN_W-1:0] char_len,
    input  logic             poly_sel,
    input  logic             preset_ones,
    input  logic             crc_en,
    input  logic             sync_strip,
    input  logic             crc_reset,
    input  logic             hunt,
    output logic [CRC_W-1:0] crc_q,
    output logic             crc_ok,
    output logic             char_load
);
    logic [BITS_W-1:0] char_bits;
    logic              dly_bit;
    logic              dly_tag;
    logic              incl;

    assign incl = crc_en && !sync_strip;

    crc_char_count #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_cnt (
        .clk           (clk),
        .rst_n         (rst_n),
        .hunt          (hunt),
        .bit_vld       (rx_bit_vld),
        .len_code      (char_len),
        .load          (char_load),
        .bits_per_char (char_bits)
    );

    crc_delay_line #(.DEPTH(DEPTH), .BITS_W(BITS_W)) u_dly (
        .clk       (clk),
        .rst_n     (rst_n),
        .hunt      (hunt),
        .shift     (rx_bit_vld),
        .din       (rx_bit),
        .load      (char_load),
        .incl      (incl),
        .char_bits (char_bits),
        .dout      (dly_bit),
        .dout_tag  (dly_tag)
    );

    crc_lfsr16 u_crc (
        .clk         (clk),
        .rst_n       (rst_n),
        .hunt        (hunt),
        .clr         (crc_reset),
        .step        (rx_bit_vld && dly_tag),
        .din         (dly_bit),
        .use_a       (poly_sel),
        .preset_ones (preset_ones),
        .crc         (crc_q)
    );

    assign crc_ok = (crc_q == '0);
endmodule

// File: rtl/crc_rx_chk.sv
module crc_rx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rx_bit_vld,
    input logic [1:0]  char_len,
    input logic        hunt,
    input logic        crc_reset,
    input logic        preset_ones,
    input logic [15:0] crc_q,
    input logic        char_load
);
    logic [3:0] seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  seen <= '0;
        else if (hunt)               seen <= '0;
        else if (char_load)          seen <= '0;
        else if (rx_bit_vld)         seen <= seen + 1'b1;
    end

    assert_hunt_preset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hunt |=> crc_q == ($past(preset_ones) ? 16'hFFFF : 16'h0000));

    assert_reset_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_reset && !hunt) |=> crc_q == ($past(preset_ones) ? 16'hFFFF : 16'h0000));

    assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_bit_vld && !hunt && !crc_reset) |=> $stable(crc_q));

    assert_load_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        char_load |-> (rx_bit_vld && (seen + 4'd1 == 4'd5 + {2'b00, char_len})));
endmodule

bind sync_rx_crc_chk crc_rx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_bit_vld  (rx_bit_vld),
    .char_len    (char_len),
    .hunt        (hunt),
    .crc_reset   (crc_reset),
    .preset_ones (preset_ones),
    .crc_q       (crc_q),
    .char_load   (char_load)
);

// File: tb/sim_sync_rx_crc_chk.sv
`timescale 1ns/1ps
module sim_sync_rx_crc_chk;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_bit_vld = 1'b0;
    logic        rx_bit = 1'b0;
    logic [1:0]  char_len = 2'b11;
    logic        poly_sel = 1'b0;
    logic        preset_ones = 1'b0;
    logic        crc_en = 1'b0;
    logic        sync_strip = 1'b0;
    logic        crc_reset = 1'b0;
    logic        hunt = 1'b0;
    logic [15:0] crc_q;
    logic        crc_ok;
    logic        char_load;

    int checks = 0;
    int fails = 0;
    logic [15:0] exp_crc;

    typedef struct {
        logic [15:0] crc;
        logic        ok;
        string       req;
    } item_t;
    item_t sb[$];

    always #2 clk = ~clk;

    sync_rx_crc_chk u0 (.*);

    function automatic logic [15:0] mstep(input logic [15:0] c, input logic b, input logic a);
        logic [15:0] p;
        p = a ? 16'h8005 : 16'h1021;
        return (c[15] ^ b) ? ((c << 1) ^ p) : (c << 1);
    endfunction

    task automatic model_char(input logic [7:0] d, input int len, input logic inc);
        if (inc) for (int i = 0; i < len; i++) exp_crc = mstep(exp_crc, d[len-1-i], poly_sel);
    endtask

    task automatic send_char(input logic [7:0] d, input int len, input logic en, input logic strip);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_bit_vld = 1'b1;
            rx_bit     = d[len-1-i];
            char_len   = 2'(len - 5);
            if (i == len - 1) begin crc_en = en;  sync_strip = strip;  end
            else              begin crc_en = !en; sync_strip = !strip; end
        end
    endtask

    task automatic expect_now(input logic [15:0] c, input string req);
        item_t it;
        @(negedge clk);
        rx_bit_vld = 1'b0; crc_en = 1'b0; sync_strip = 1'b0;
        #1;
        it.crc = c; it.ok = (c == 16'h0000); it.req = req;
        sb.push_back(it);
        wait (sb.size() == 0);
    endtask

    task automatic do_hunt();
        @(negedge clk);
        rx_bit_vld = 1'b0; hunt = 1'b1;
        @(negedge clk);
        hunt = 1'b0;
        exp_crc = preset_ones ? 16'hFFFF : 16'h0000;
    endtask

    task automatic flush();
        send_char(8'h00, 8, 1'b0, 1'b0);
    endtask

    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (crc_q !== it.crc || crc_ok !== it.ok) begin
                fails++;
                $display("FAIL %s: crc=%h ok=%b expected crc=%h ok=%b", it.req, crc_q, crc_ok, it.crc, it.ok);
            end
        end
    end

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog: run hung, actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] fr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state (R10: zero remainder reads ok)
        checks++;
        if (crc_q !== 16'h0 || crc_ok !== 1'b1 || char_load !== 1'b0) begin
            fails++;
            $display("FAIL R10 reset: crc=%h ok=%b load=%b expected 0000 1 0", crc_q, crc_ok, char_load);
        end

        // R2 R3: hunt with ones preset
        preset_ones = 1'b1; do_hunt();
        expect_now(16'hFFFF, "R2 R3 hunt preset ones");

        // R6: delay line lag
        poly_sel = 1'b0;
        send_char(8'hA5, 8, 1'b1, 1'b0);
        expect_now(16'hFFFF, "R6 no bits exited yet");
        send_char(8'h00, 5, 1'b0, 1'b0);
        for (int i = 0; i < 5; i++) exp_crc = mstep(exp_crc, 1'(8'hA5 >> (7 - i)), 1'b0);
        expect_now(exp_crc, "R6 five bits exited");

        // R1 R10: CCITT, preset 0, frame + appended CRC
        preset_ones = 1'b0; do_hunt();
        send_char(8'h31, 8, 1'b1, 1'b0); model_char(8'h31, 8, 1'b1);
        send_char(8'h32, 8, 1'b1, 1'b0); model_char(8'h32, 8, 1'b1);
        send_char(8'h33, 8, 1'b1, 1'b0); model_char(8'h33, 8, 1'b1);
        flush();
        expect_now(exp_crc, "R1 ccitt remainder");
        fr = exp_crc;
        send_char(fr[15:8], 8, 1'b1, 1'b0);
        send_char(fr[7:0], 8, 1'b1, 1'b0);
        flush();
        expect_now(16'h0000, "R10 ccitt appended zero");

        // R1 R10: CRC-16 polynomial
        poly_sel = 1'b1; do_hunt();
        send_char(8'hC3, 8, 1'b1, 1'b0); model_char(8'hC3, 8, 1'b1);
        send_char(8'h7E, 8, 1'b1, 1'b0); model_char(8'h7E, 8, 1'b1);
        flush();
        expect_now(exp_crc, "R1 crc16 remainder");
        fr = exp_crc;
        send_char(fr[15:8], 8, 1'b1, 1'b0);
        send_char(fr[7:0], 8, 1'b1, 1'b0);
        flush();
        expect_now(16'h0000, "R10 crc16 appended zero");

        // R2 R10: ones preset, appended CRC
        poly_sel = 1'b0; preset_ones = 1'b1; do_hunt();
        send_char(8'h5A, 8, 1'b1, 1'b0); model_char(8'h5A, 8, 1'b1);
        flush();
        fr = exp_crc;
        send_char(fr[15:8], 8, 1'b1, 1'b0);
        send_char(fr[7:0], 8, 1'b1, 1'b0);
        flush();
        expect_now(16'h0000, "R2 R10 ones preset appended zero");

        // R8: stripped sync excluded
        preset_ones = 1'b0; do_hunt();
        send_char(8'h16, 8, 1'b1, 1'b1); model_char(8'h16, 8, 1'b0);
        send_char(8'h9C, 8, 1'b1, 1'b0); model_char(8'h9C, 8, 1'b1);
        flush();
        expect_now(exp_crc, "R8 sync strip excluded");

        // R7: only load-cycle enable counts
        do_hunt();
        send_char(8'h41, 8, 1'b1, 1'b0); model_char(8'h41, 8, 1'b1);
        send_char(8'hE7, 8, 1'b0, 1'b0); model_char(8'hE7, 8, 1'b0);
        send_char(8'h28, 8, 1'b1, 1'b0); model_char(8'h28, 8, 1'b1);
        flush();
        expect_now(exp_crc, "R7 enable sampled at load");

        // R9: 5, 6, 7 bit characters
        poly_sel = 1'b1; do_hunt();
        send_char(8'h15, 5, 1'b1, 1'b0); model_char(8'h15, 5, 1'b1);
        send_char(8'h2B, 6, 1'b1, 1'b0); model_char(8'h2B, 6, 1'b1);
        send_char(8'h66, 7, 1'b1, 1'b0); model_char(8'h66, 7, 1'b1);
        send_char(8'h0A, 5, 1'b0, 1'b0); model_char(8'h0A, 5, 1'b0);
        flush();
        expect_now(exp_crc, "R9 short characters");

        // R4: reset command mid-stream
        send_char(8'hF0, 8, 1'b1, 1'b0);
        @(negedge clk); rx_bit_vld = 1'b0; preset_ones = 1'b1; crc_reset = 1'b1;
        @(negedge clk); crc_reset = 1'b0;
        expect_now(16'hFFFF, "R4 reset command preset");
        flush(); // leftover tagged bits drain after reset
        exp_crc = 16'hFFFF;
        model_char(8'hF0, 8, 1'b1);
        expect_now(exp_crc, "R4 accumulation resumes");

        // R3: hunt realigns characters and clears tags
        preset_ones = 1'b0; poly_sel = 1'b0;
        send_char(8'h07, 3, 1'b1, 1'b0);
        do_hunt();
        send_char(8'hB2, 8, 1'b1, 1'b0); model_char(8'hB2, 8, 1'b1);
        flush();
        expect_now(exp_crc, "R3 hunt realign");

        // R5: idle holds
        repeat (5) @(negedge clk);
        expect_now(exp_crc, "R5 idle hold");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule